// File: doc/BRIEF.md
# DSP Host Control and Halt Sequencer

This block sits between a host processor and a small signal-processing core. The host reaches it through a byte-wide register port that has a 5-bit offset, write data, and read and write strobes. Through that port the host sets a three-byte DRAM address latch and a RAM-select flag, and it works a control register. The control register carries a refresh-disable flag, a memory-clear request and an active-low host-access flag.

The core runs its program in passes. The datapath pulses `pass_end_i` on the last step of each pass. At that point the block does three things: it returns the program counter to 0, it moves the delay-line base pointer down by `mem_incr_i`, and it samples `halt_i`. If `halt_i` is high, the core parks in a halted state and the host is given access. Once halted, a low `halt_i` restarts the core at program counter 0 and takes host access back.

While the core is halted, the host can ask for the delay memory to be filled with zeros. A sequencer then writes every address, one per clock, through a simple write port. The core cannot leave the halted state until that fill has finished.

Top module: `dsp_host_ctrl`

## Requirements
- R1: After reset the control register (offset 0x12) reads 0x04, the core is running, and the program counter, base pointer, DRAM latch, RAM-select, refresh-disable and busy are all 0.
- R2: A write to offset 0x12 loads control bit 0 (refresh disable, shown on `refresh_dis_o`) from data bit 0, and the host cannot change bit 2. The control register reads as {5'b0, bit2 = access-denied, bit1 = clear busy, bit0 = refresh disable}.
- R3: While running, if `pass_end_i` and `halt_i` are both high at a clock edge, the core is halted after that edge and bit 2 / `host_nok_o` is 0.
- R4: While halted, with no fill active or starting, a low `halt_i` at a clock edge puts the core back to running after that edge, with bit 2 set to 1 and the program counter at 0.
- R5: At every edge where the core is running and `pass_end_i` is high, the base pointer drops by `mem_incr_i` (modulo 2^AW) and the program counter becomes 0.
- R6: While running, the program counter rises by 1 at each edge without `pass_end_i`, and holds while halted. A read of offset 0x16 returns its low 8 bits.
- R7: Writing control bit 1 = 1 while halted and idle starts a fill. From the next cycle on, `mem_we_o` is high for exactly MEM_DEPTH cycles, with addresses 0 up to MEM_DEPTH-1 in order and write data 0. Bit 1 and `busy_o` read 1 for the length of the fill and 0 after it.
- R8: Writing control bit 1 = 1 while running writes no memory, and bit 1 reads back as 0.
- R9: The core stays halted while a fill runs, even when `halt_i` is low. It can leave the halted state no earlier than the edge after `busy_o` falls.
- R10: Offsets 0x0F, 0x10 and 0x11 write and read the high, middle and low bytes of the 24-bit DRAM latch. A write to one byte leaves the other two unchanged.
- R11: A write to offset 0x14 sets `ram_sel_o` to data bit 7 and ignores bits 6:0.
- R12: A read of any offset other than 0x0F, 0x10, 0x11, 0x12 or 0x16 returns 0, and that includes 0x14. With `host_rd_i` low the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 5 | Host register offset |
| host_wdata_i | input | 8 | Host write data |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Host read data, combinational |
| halt_i | input | 1 | Halt request, sampled at pass end and while halted |
| pass_end_i | input | 1 | Last step of a program pass |
| mem_incr_i | input | AW | Per-pass base pointer decrement |
| halted_o | output | 1 | Core is in the halted state |
| host_nok_o | output | 1 | Host access denied (active-low grant) |
| pc_o | output | PC_W | Program counter |
| dbase_o | output | AW | Delay-line base pointer |
| dadr_o | output | 24 | DRAM address latch |
| ram_sel_o | output | 1 | RAM-select flag |
| refresh_dis_o | output | 1 | Refresh-disable flag |
| busy_o | output | 1 | Zero-fill in progress |
| mem_we_o | output | 1 | Delay memory write enable |
| mem_addr_o | output | AW | Delay memory write address |
| mem_wdata_o | output | DW | Delay memory write data (zero) |

## Verification
The bench targets the following corner cases:
- **Fill bounds.** It counts fill writes from the first address to the last. A sequencer that stops one address early or late, or that starts at a non-zero address, shows up as a wrong address or a wrong count.
- **Release of HALT during a fill.** `halt_i` is dropped while the fill runs. A design that exits on the first low sample would be running while `busy_o` is still high.
- **Clear request while running.** This case catches a bit 1 that sticks, and also any stray write pulse.
- **Writes that must not reach a field.** Bit 2 is written as 1 and as 0, and 0x14 is written with only its low bits set. A decode that stores bits it should not would change the readback or `ram_sel_o`.
- **Random run.** Random halt, pass-end and register traffic exercise the active-low access flag, the restart at PC 0 and base pointer wraparound, cycle by cycle.

// File: rtl/dsp_host_pkg.sv
package dsp_host_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} run_state_e;

  localparam int          HOST_AW   = 5;
  localparam int          DADR_W    = 24;
  localparam int          DADR_NB   = DADR_W / 8;
  localparam logic [4:0]  OFS_DADR_H = 5'h0f;
  localparam logic [4:0]  OFS_CTRL   = 5'h12;
  localparam logic [4:0]  OFS_RSEL   = 5'h14;
  localparam logic [4:0]  OFS_PC     = 5'h16;

  localparam int CB_REFR = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_NOK  = 2;
endpackage

// File: rtl/host_regs.sv
module host_regs
  import dsp_host_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HOST_AW-1:0]   addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [7:0]           rdata_o,
  input  logic                 halted_i,
  input  logic                 busy_i,
  input  logic                 nok_i,
  input  logic [PC_W-1:0]      pc_i,
  output logic [DADR_W-1:0]    dadr_o,
  output logic                 ram_sel_o,
  output logic                 refresh_dis_o,
  output logic                 clr_start_o
);
  logic [7:0] dadr_b [DADR_NB];
  logic [7:0] ctrl_rd;
  logic [7:0] pc_rd;

  // byte k sits at offset OFS_DADR_H + (DADR_NB-1-k)
  for (genvar k = 0; k < DADR_NB; k++) begin : g_dadr
    localparam logic [HOST_AW-1:0] OFS = OFS_DADR_H + HOST_AW'(DADR_NB - 1 - k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 dadr_b[k] <= '0;
      else if (wr_i && addr_i == OFS) dadr_b[k] <= wdata_i;
    end
    assign dadr_o[k*8 +: 8] = dadr_b[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_sel_o     <= 1'b0;
      refresh_dis_o <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == OFS_RSEL) ram_sel_o     <= wdata_i[7];
      if (addr_i == OFS_CTRL) refresh_dis_o <= wdata_i[CB_REFR];
    end
  end

  // clear only honoured while parked and idle; otherwise the request is dropped
  assign clr_start_o = wr_i && (addr_i == OFS_CTRL) && wdata_i[CB_CLR] && halted_i && !busy_i;

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_REFR] = refresh_dis_o;
    ctrl_rd[CB_CLR]  = busy_i;
    ctrl_rd[CB_NOK]  = nok_i;
  end

  assign pc_rd = 8'(pc_i);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      for (int k = 0; k < DADR_NB; k++)
        if (addr_i == OFS_DADR_H + HOST_AW'(DADR_NB - 1 - k)) rdata_o = dadr_b[k];
      if (addr_i == OFS_CTRL) rdata_o = ctrl_rd;
      if (addr_i == OFS_PC)   rdata_o = pc_rd;
    end
  end
endmodule

// File: rtl/run_seq.sv
module run_seq
  import dsp_host_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int AW   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            halt_i,
  input  logic            pass_end_i,
  input  logic            hold_i,
  input  logic [AW-1:0]   mem_incr_i,
  output logic            halted_o,
  output logic            nok_o,
  output logic [PC_W-1:0] pc_o,
  output logic [AW-1:0]   dbase_o
);
  run_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      nok_o   <= 1'b1;
      pc_o    <= '0;
      dbase_o <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (pass_end_i) begin
            pc_o    <= '0;
            dbase_o <= dbase_o - mem_incr_i;
            if (halt_i) begin
              state_q <= ST_HALT;
              nok_o   <= 1'b0;
            end
          end else begin
            pc_o <= pc_o + 1'b1;
          end
        end
        ST_HALT: begin
          if (!halt_i && !hold_i) begin
            state_q <= ST_RUN;
            nok_o   <= 1'b1;
            pc_o    <= '0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/mem_clear.sv
module mem_clear #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == LAST) busy_o <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign we_o    = busy_o;
  assign addr_o  = cnt_q;
  assign wdata_o = '0;
endmodule

// File: rtl/dsp_host_ctrl.sv
module dsp_host_ctrl
  import dsp_host_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int DW        = 24,
  parameter int PC_W      = 8,
  localparam int AW       = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        host_addr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  output logic [7:0]        host_rdata_o,
  input  logic              halt_i,
  input  logic              pass_end_i,
  input  logic [AW-1:0]     mem_incr_i,
  output logic              halted_o,
  output logic              host_nok_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [AW-1:0]     dbase_o,
  output logic [23:0]       dadr_o,
  output logic              ram_sel_o,
  output logic              refresh_dis_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o
);
  logic clr_start;

  host_regs #(.PC_W(PC_W)) i_regs (
    .clk_i, .rst_ni,
    .addr_i        (host_addr_i),
    .wdata_i       (host_wdata_i),
    .wr_i          (host_wr_i),
    .rd_i          (host_rd_i),
    .rdata_o       (host_rdata_o),
    .halted_i      (halted_o),
    .busy_i        (busy_o),
    .nok_i         (host_nok_o),
    .pc_i          (pc_o),
    .dadr_o        (dadr_o),
    .ram_sel_o     (ram_sel_o),
    .refresh_dis_o (refresh_dis_o),
    .clr_start_o   (clr_start)
  );

  run_seq #(.PC_W(PC_W), .AW(AW)) i_seq (
    .clk_i, .rst_ni,
    .halt_i     (halt_i),
    .pass_end_i (pass_end_i),
    .hold_i     (busy_o | clr_start),
    .mem_incr_i (mem_incr_i),
    .halted_o   (halted_o),
    .nok_o      (host_nok_o),
    .pc_o       (pc_o),
    .dbase_o    (dbase_o)
  );

  mem_clear #(.DEPTH(MEM_DEPTH), .AW(AW), .DW(DW)) i_clr (
    .clk_i, .rst_ni,
    .start_i (clr_start),
    .busy_o  (busy_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/dsp_host_ctrl_chk.sv
module dsp_host_ctrl_chk #(
  parameter int AW   = 10,
  parameter int DW   = 24,
  parameter int PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            halt_i,
  input logic            pass_end_i,
  input logic [AW-1:0]   mem_incr_i,
  input logic            halted_o,
  input logic            host_nok_o,
  input logic [PC_W-1:0] pc_o,
  input logic [AW-1:0]   dbase_o,
  input logic            busy_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_wdata_o
);
  // R3
  halt_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(pass_end_i) && $past(halt_i) && !host_nok_o);
  // R4
  restart_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> pc_o == '0 && host_nok_o);
  // R5
  dbase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && pass_end_i) |=> dbase_o == $past(dbase_o) - $past(mem_incr_i));
  // R7
  fill_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o == '0);
  // R7
  fill_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> mem_addr_o == '0);
  // R7
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R8
  fill_only_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(halted_o));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> halted_o);
endmodule

bind dsp_host_ctrl dsp_host_ctrl_chk #(.AW(AW), .DW(DW), .PC_W(PC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_i),
  .pass_end_i  (pass_end_i),
  .mem_incr_i  (mem_incr_i),
  .halted_o    (halted_o),
  .host_nok_o  (host_nok_o),
  .pc_o        (pc_o),
  .dbase_o     (dbase_o),
  .busy_o      (busy_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/test_dsp_host_ctrl.sv
`timescale 1ns/1ps
module test_dsp_host_ctrl;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int DW    = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [4:0]    host_addr_i = '0;
  logic [7:0]    host_wdata_i = '0;
  logic          host_wr_i = 1'b0;
  logic          host_rd_i = 1'b0;
  logic [7:0]    host_rdata_o;
  logic          halt_i = 1'b0;
  logic          pass_end_i = 1'b0;
  logic [AW-1:0] mem_incr_i = '0;
  logic          halted_o, host_nok_o, ram_sel_o, refresh_dis_o, busy_o, mem_we_o;
  logic [7:0]    pc_o;
  logic [AW-1:0] dbase_o, mem_addr_o;
  logic [23:0]   dadr_o;
  logic [DW-1:0] mem_wdata_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  dsp_host_ctrl #(.MEM_DEPTH(DEPTH), .DW(DW), .PC_W(8)) i_dsp_host_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // host read, issued in the low clock phase
  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    host_addr_i = a; host_rd_i = 1'b1;
    #0.5 d = host_rdata_o;
    host_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  function automatic logic [7:0] ctrl_exp(logic halted, logic busy, logic refr);
    return {5'b0, !halted, busy, refr};
  endfunction

  // model state for random phase
  logic          m_halt;
  logic [7:0]    m_pc;
  logic [AW-1:0] m_dbase;
  logic [23:0]   m_dadr;
  logic          m_rsel, m_refr;

  initial begin
    logic [7:0] d;
    logic [7:0] p0;
    logic [AW-1:0] b0;
    void'($urandom(32'd4242));
    #12 @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd(5'h12, d); chk("R1 ctrl", d, 8'h04);
    chk("R1 halted", halted_o, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 dbase", dbase_o, 0);
    chk("R1 misc", {dadr_o, ram_sel_o, refresh_dis_o, busy_o}, 0);

    // R6 pc counts while running
    p0 = pc_o; step();
    chk("R6 pc inc", pc_o, 8'(p0 + 1));
    rd(5'h16, d); chk("R6 pc read", d, pc_o);

    // R2 bit2 not writable, bit0 stored
    wr(5'h12, 8'hFD);
    rd(5'h12, d); chk("R2 ctrl", d, 8'h05);
    chk("R2 refresh", refresh_dis_o, 1);
    wr(5'h12, 8'h00);
    rd(5'h12, d); chk("R2 ctrl clr", d, 8'h04);

    // R8 clear request while running is dropped
    host_addr_i = 5'h12; host_wdata_i = 8'h02; host_wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); host_wr_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R8 no write", {mem_we_o, busy_o}, 0);
      step();
    end
    rd(5'h12, d); chk("R8 bit1", d, 8'h04);

    // R10 dram latch bytes
    wr(5'h0f, 8'hA1); wr(5'h10, 8'hB2); wr(5'h11, 8'hC3);
    chk("R10 latch", dadr_o, 24'hA1B2C3);
    wr(5'h10, 8'h5E);
    chk("R10 one byte", dadr_o, 24'hA15EC3);
    rd(5'h0f, d); chk("R10 rd h", d, 8'hA1);
    rd(5'h10, d); chk("R10 rd m", d, 8'h5E);
    rd(5'h11, d); chk("R10 rd l", d, 8'hC3);

    // R11 ram select
    wr(5'h14, 8'h7F); chk("R11 low bits", ram_sel_o, 0);
    wr(5'h14, 8'h80); chk("R11 bit7", ram_sel_o, 1);

    // R12 undecoded reads
    rd(5'h14, d); chk("R12 0x14", d, 0);
    rd(5'h03, d); chk("R12 0x03", d, 0);
    rd(5'h1f, d); chk("R12 0x1f", d, 0);
    host_addr_i = 5'h12; #0.5 chk("R12 no rd", host_rdata_o, 0);

    // R5 + R3 pass end with halt
    b0 = dbase_o;
    mem_incr_i = 4'd3; pass_end_i = 1'b1; halt_i = 1'b1;
    step(); pass_end_i = 1'b0;
    chk("R3 halted", halted_o, 1);
    chk("R3 nok", host_nok_o, 0);
    chk("R5 dbase", dbase_o, AW'(b0 - 4'd3));
    chk("R5 pc", pc_o, 0);
    step(); chk("R6 pc hold", pc_o, 0);
    rd(5'h12, d); chk("R3 ctrl", d, 8'h00);

    // R7 + R9 fill while halted, halt released mid fill
    host_addr_i = 5'h12; host_wdata_i = 8'h02; host_wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); host_wr_i = 1'b0; halt_i = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      chk("R7 we", mem_we_o, 1);
      chk("R7 addr", mem_addr_o, k);
      chk("R7 data", mem_wdata_o, 0);
      chk("R9 held", halted_o, 1);
      if (k == 3) begin rd(5'h12, d); chk("R7 bit1 busy", d, 8'h02); end
      step();
    end
    chk("R7 done", {mem_we_o, busy_o}, 0);
    chk("R9 still halted", halted_o, 1);
    rd(5'h12, d); chk("R7 bit1 low", d, 8'h00);
    step();
    chk("R4 running", halted_o, 0);
    chk("R4 nok", host_nok_o, 1);
    chk("R4 pc", pc_o, 0);

    // random phase against bench model
    rst_ni = 1'b0; #3 rst_ni = 1'b1;
    m_halt = 0; m_pc = 0; m_dbase = 0; m_dadr = 0; m_rsel = 0; m_refr = 0;
    for (int n = 0; n < 3000; n++) begin
      logic h, pe, w;
      logic [2:0] sel;
      logic [7:0] wd;
      logic [AW-1:0] inc;
      logic [4:0] wa;
      rd(5'h16, d); chk("R6 rand pc", d, m_pc);
      rd(5'h12, d); chk("R2 rand ctrl", d, ctrl_exp(m_halt, 1'b0, m_refr));
      chk("R3 R4 rand halted", {halted_o, host_nok_o}, {m_halt, !m_halt});
      chk("R5 rand dbase", dbase_o, m_dbase);
      chk("R10 R11 rand regs", {dadr_o, ram_sel_o, refresh_dis_o}, {m_dadr, m_rsel, m_refr});
      chk("R8 rand no fill", mem_we_o, 0);
      h = ($urandom % 2) == 0;
      pe = ($urandom % 3) == 0;
      inc = AW'($urandom);
      w = ($urandom % 3) == 0;
      sel = 3'($urandom % 5);
      wd = 8'($urandom);
      case (sel)
        3'd0: wa = 5'h0f;
        3'd1: wa = 5'h10;
        3'd2: wa = 5'h11;
        3'd3: wa = 5'h14;
        default: begin wa = 5'h12; wd[1] = 1'b0; end
      endcase
      halt_i = h; pass_end_i = pe; mem_incr_i = inc;
      host_addr_i = wa; host_wdata_i = wd; host_wr_i = w;
      @(posedge clk_i);
      if (!m_halt) begin
        if (pe) begin
          m_pc = 0; m_dbase = m_dbase - inc;
          if (h) m_halt = 1;
        end else m_pc = m_pc + 1;
      end else if (!h) begin
        m_halt = 0; m_pc = 0;
      end
      if (w) begin
        case (wa)
          5'h0f: m_dadr[23:16] = wd;
          5'h10: m_dadr[15:8] = wd;
          5'h11: m_dadr[7:0] = wd;
          5'h14: m_rsel = wd[7];
          default: m_refr = wd[0];
        endcase
      end
      @(negedge clk_i);
      host_wr_i = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900us;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule